// File: doc/BRIEF.md
# Dual-Port Memory with Semaphore Port Front-End

This block is a synchronous 4096 x 8 memory with two identical, fully independent ports, left and right. Each port has its own enable pins, address, write data and registered read data. It also has a small request path to a separate flag unit that holds eight semaphore flags. A port uses two active-low selects to choose what it accesses. One select opens the memory space and the other opens the semaphore space. When neither is active the port is in standby. When both are active the combination is refused.

Both ports may work in the same cycle. If they write the same word, the left port's value is kept and a collision pulse follows. A read that meets an opposite-port write to the same word returns the value held before that write. Semaphore accesses only address the flag unit: the three low address bits select a flag, and a write forwards data bit 0. The value read back is that flag bit copied onto all eight data lines.

Top module: `dpsram_ports`

## Requirements
- R1: A memory read (memory select low, flag select high, write strobe high, read enable low) presents the word at the addressed location on the port's read data one clock later, with read-valid high in that cycle; memory writes use write strobe low with the same selects.
- R2: With both memory select and flag select high, the port's standby output is high, no semaphore request is issued, and read-valid is low one clock later.
- R3: With both selects low, the illegal output is high, memory is not written, no semaphore request is issued, and read-valid is low one clock later.
- R4: A read selection with read enable high produces no data: read-valid is low one clock later.
- R5: In semaphore space (memory select high, flag select low), a write raises the request and write-flag outputs in the same cycle. The flag index output carries address bits 2..0, the flag bit output carries write-data bit 0, address bits 11..3 are ignored, and memory is left unchanged.
- R6: A semaphore read with read enable low raises a request with write-flag low, and one clock later returns the port's flag input copied to all 8 data bits, with read-valid high.
- R7: When both ports write the same address in one cycle, the left port's data is stored and the collision output is high for one cycle, one clock later; writes to different addresses leave it low.
- R8: When one port reads an address in the same cycle that the other port writes it, the reader receives the old contents.
- R9: After reset, read-valid on both ports, both read data buses and the collision output are zero.
- R10: Both ports may read different addresses in the same cycle, and each receives its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lt_mem_sel_n | input | 1 | Left memory-space select, active low |
| lt_flag_sel_n | input | 1 | Left semaphore-space select, active low |
| lt_rd_n | input | 1 | Left read enable, active low |
| lt_wr_n | input | 1 | Left write strobe, low = write |
| lt_addr | input | 12 | Left address |
| lt_wdata | input | 8 | Left write data |
| lt_rdata | output | 8 | Left registered read data |
| lt_rvalid | output | 1 | Left read data valid |
| lt_standby | output | 1 | Left port deselected |
| lt_illegal | output | 1 | Left select combination refused |
| lt_sreq | output | 1 | Left semaphore request |
| lt_swr | output | 1 | Left semaphore request is a write |
| lt_sidx | output | 3 | Left semaphore index |
| lt_sbit | output | 1 | Left semaphore write bit |
| lt_sflag | input | 1 | Left flag value from the semaphore unit |
| rt_mem_sel_n | input | 1 | Right memory-space select, active low |
| rt_flag_sel_n | input | 1 | Right semaphore-space select, active low |
| rt_rd_n | input | 1 | Right read enable, active low |
| rt_wr_n | input | 1 | Right write strobe, low = write |
| rt_addr | input | 12 | Right address |
| rt_wdata | input | 8 | Right write data |
| rt_rdata | output | 8 | Right registered read data |
| rt_rvalid | output | 1 | Right read data valid |
| rt_standby | output | 1 | Right port deselected |
| rt_illegal | output | 1 | Right select combination refused |
| rt_sreq | output | 1 | Right semaphore request |
| rt_swr | output | 1 | Right semaphore request is a write |
| rt_sidx | output | 3 | Right semaphore index |
| rt_sbit | output | 1 | Right semaphore write bit |
| rt_sflag | input | 1 | Right flag value from the semaphore unit |
| collide | output | 1 | Same-address write collision pulse |

## Verification
The status and semaphore request outputs are combinational and are due in the same cycle as the stimulus. The bench checks them one time unit after it drives the inputs. Read data, read-valid and the collision pulse are registered and are due after the next rising edge. For each stimulus cycle the driver pushes an item tagged with that edge's cycle number. The monitor pops and compares the items shortly after the edge, so every registered result is compared in exactly the cycle it is due.

// File: rtl/dpsram_ports.sv
module dpsram_ports #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lt_mem_sel_n,
  input  logic          lt_flag_sel_n,
  input  logic          lt_rd_n,
  input  logic          lt_wr_n,
  input  logic [AW-1:0] lt_addr,
  input  logic [DW-1:0] lt_wdata,
  output logic [DW-1:0] lt_rdata,
  output logic          lt_rvalid,
  output logic          lt_standby,
  output logic          lt_illegal,
  output logic          lt_sreq,
  output logic          lt_swr,
  output logic [SW-1:0] lt_sidx,
  output logic          lt_sbit,
  input  logic          lt_sflag,
  input  logic          rt_mem_sel_n,
  input  logic          rt_flag_sel_n,
  input  logic          rt_rd_n,
  input  logic          rt_wr_n,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rt_wdata,
  output logic [DW-1:0] rt_rdata,
  output logic          rt_rvalid,
  output logic          rt_standby,
  output logic          rt_illegal,
  output logic          rt_sreq,
  output logic          rt_swr,
  output logic [SW-1:0] rt_sidx,
  output logic          rt_sbit,
  input  logic          rt_sflag,
  output logic          collide
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic [1:0] msel_n, fsel_n, rd_n, wr_n, sflag;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [1:0] rvalid;

  assign msel_n = {rt_mem_sel_n, lt_mem_sel_n};
  assign fsel_n = {rt_flag_sel_n, lt_flag_sel_n};
  assign rd_n   = {rt_rd_n, lt_rd_n};
  assign wr_n   = {rt_wr_n, lt_wr_n};
  assign sflag  = {rt_sflag, lt_sflag};
  assign addr[0]  = lt_addr;
  assign addr[1]  = rt_addr;
  assign wdata[0] = lt_wdata;
  assign wdata[1] = rt_wdata;

  logic [1:0] mem_on, flag_on, mwr, mrd, fwr, frd;

  assign mem_on  = ~msel_n & fsel_n;
  assign flag_on = msel_n & ~fsel_n;
  assign mwr = mem_on & ~wr_n;
  assign mrd = mem_on & wr_n & ~rd_n;
  assign fwr = flag_on & ~wr_n;
  assign frd = flag_on & wr_n & ~rd_n;

  assign lt_standby = msel_n[0] & fsel_n[0];
  assign rt_standby = msel_n[1] & fsel_n[1];
  assign lt_illegal = ~msel_n[0] & ~fsel_n[0];
  assign rt_illegal = ~msel_n[1] & ~fsel_n[1];

  assign lt_sreq = fwr[0] | frd[0];
  assign rt_sreq = fwr[1] | frd[1];
  assign lt_swr  = fwr[0];
  assign rt_swr  = fwr[1];
  assign lt_sidx = lt_addr[SW-1:0];
  assign rt_sidx = rt_addr[SW-1:0];
  assign lt_sbit = lt_wdata[0];
  assign rt_sbit = rt_wdata[0];

  always_ff @(posedge clk) begin
    if (mwr[1]) mem[addr[1]] <= wdata[1];
    if (mwr[0]) mem[addr[0]] <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid  <= '0;
      rdata   <= '{default: '0};
      collide <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        rvalid[i] <= mrd[i] | frd[i];
        if (mrd[i])      rdata[i] <= mem[addr[i]];
        else if (frd[i]) rdata[i] <= {DW{sflag[i]}};
      end
      collide <= mwr[0] & mwr[1] & (addr[0] == addr[1]);
    end
  end

  assign lt_rdata  = rdata[0];
  assign rt_rdata  = rdata[1];
  assign lt_rvalid = rvalid[0];
  assign rt_rvalid = rvalid[1];
endmodule

module dpsram_ports_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lt_mem_sel_n,
  input logic          lt_flag_sel_n,
  input logic          lt_rd_n,
  input logic          lt_wr_n,
  input logic [AW-1:0] lt_addr,
  input logic          rt_mem_sel_n,
  input logic          rt_flag_sel_n,
  input logic          rt_wr_n,
  input logic [AW-1:0] rt_addr,
  input logic          lt_rvalid,
  input logic          lt_standby,
  input logic          lt_illegal,
  input logic          lt_sreq,
  input logic          collide
);
  logic both_wr_same;
  assign both_wr_same = !lt_mem_sel_n && lt_flag_sel_n && !lt_wr_n &&
                        !rt_mem_sel_n && rt_flag_sel_n && !rt_wr_n &&
                        (lt_addr == rt_addr);

  // R3
  illegal_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_illegal |-> !lt_sreq);

  // R3
  illegal_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_illegal |=> !lt_rvalid);

  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_standby |=> !lt_rvalid);

  // R4
  read_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_mem_sel_n && lt_flag_sel_n && lt_wr_n && lt_rd_n) |=> !lt_rvalid);

  // R7
  collide_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    both_wr_same |=> collide);

  // R7
  collide_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $past(both_wr_same));

  // R1
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_rvalid |-> $past(lt_sreq || (!lt_mem_sel_n && lt_flag_sel_n && lt_wr_n && !lt_rd_n)));
endmodule

bind dpsram_ports dpsram_ports_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lt_mem_sel_n(lt_mem_sel_n), .lt_flag_sel_n(lt_flag_sel_n),
  .lt_rd_n(lt_rd_n), .lt_wr_n(lt_wr_n), .lt_addr(lt_addr),
  .rt_mem_sel_n(rt_mem_sel_n), .rt_flag_sel_n(rt_flag_sel_n),
  .rt_wr_n(rt_wr_n), .rt_addr(rt_addr),
  .lt_rvalid(lt_rvalid), .lt_standby(lt_standby), .lt_illegal(lt_illegal),
  .lt_sreq(lt_sreq), .collide(collide)
);

// File: tb/tb_dpsram_ports.sv
module tb_dpsram_ports;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic l_ms, l_fs, l_rd, l_wr, l_sf, r_ms, r_fs, r_rd, r_wr, r_sf;
  logic [11:0] l_a, r_a;
  logic [7:0]  l_d, r_d;
  logic [7:0]  l_q, r_q;
  logic l_v, r_v, l_sb, r_sb, l_il, r_il, l_sq, r_sq, l_sw, r_sw, l_bt, r_bt, coll;
  logic [2:0] l_ix, r_ix;

  dpsram_ports dut (
    .clk(clk), .rst_n(rst_n),
    .lt_mem_sel_n(l_ms), .lt_flag_sel_n(l_fs), .lt_rd_n(l_rd), .lt_wr_n(l_wr),
    .lt_addr(l_a), .lt_wdata(l_d), .lt_rdata(l_q), .lt_rvalid(l_v),
    .lt_standby(l_sb), .lt_illegal(l_il), .lt_sreq(l_sq), .lt_swr(l_sw),
    .lt_sidx(l_ix), .lt_sbit(l_bt), .lt_sflag(l_sf),
    .rt_mem_sel_n(r_ms), .rt_flag_sel_n(r_fs), .rt_rd_n(r_rd), .rt_wr_n(r_wr),
    .rt_addr(r_a), .rt_wdata(r_d), .rt_rdata(r_q), .rt_rvalid(r_v),
    .rt_standby(r_sb), .rt_illegal(r_il), .rt_sreq(r_sq), .rt_swr(r_sw),
    .rt_sidx(r_ix), .rt_sbit(r_bt), .rt_sflag(r_sf),
    .collide(coll)
  );

  typedef struct {
    int due; int port; logic valid; logic [7:0] data; string req;
  } item_t;
  item_t q[$];
  logic [7:0] model [4096];
  int cyc = 0, total = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ctl = {mem_sel_n, flag_sel_n, rd_n, wr_n}
  task automatic drive(string req,
                       logic [3:0] lc, logic [11:0] la, logic [7:0] ld, logic lf,
                       logic [3:0] rc, logic [11:0] ra, logic [7:0] rd, logic rf);
    logic [3:0] c [2];
    logic [11:0] a [2];
    logic [7:0] d [2];
    logic f [2];
    logic mw [2];
    c[0] = lc; c[1] = rc; a[0] = la; a[1] = ra; d[0] = ld; d[1] = rd; f[0] = lf; f[1] = rf;
    @(negedge clk);
    {l_ms, l_fs, l_rd, l_wr} = lc; l_a = la; l_d = ld; l_sf = lf;
    {r_ms, r_fs, r_rd, r_wr} = rc; r_a = ra; r_d = rd; r_sf = rf;
    for (int i = 0; i < 2; i++) begin
      logic mem_on, flg_on, v;
      logic [7:0] e;
      mem_on = !c[i][3] && c[i][2];
      flg_on = c[i][3] && !c[i][2];
      mw[i] = mem_on && !c[i][0];
      v = (mem_on || flg_on) && c[i][0] && !c[i][1];
      e = mem_on ? model[a[i]] : {8{f[i]}};
      q.push_back('{cyc + 1, i, v, e, req});
    end
    q.push_back('{cyc + 1, 2, mw[0] && mw[1] && (a[0] == a[1]), 8'h0, req});
    #1;
    for (int i = 0; i < 2; i++) begin
      logic sb, il, sq, sw;
      sb = c[i][3] && c[i][2];
      il = !c[i][3] && !c[i][2];
      sw = c[i][3] && !c[i][2] && !c[i][0];
      sq = sw || (c[i][3] && !c[i][2] && c[i][0] && !c[i][1]);
      chk(req, i ? "rt_standby" : "lt_standby", i ? r_sb : l_sb, sb);
      chk(req, i ? "rt_illegal" : "lt_illegal", i ? r_il : l_il, il);
      chk(req, i ? "rt_sreq" : "lt_sreq", i ? r_sq : l_sq, sq);
      if (sq) begin
        chk(req, "swr", i ? r_sw : l_sw, sw);
        chk(req, "sidx", i ? r_ix : l_ix, a[i][2:0]);
        if (sw) chk(req, "sbit", i ? r_bt : l_bt, d[i][0]);
      end
    end
    if (mw[1]) model[a[1]] = d[1];
    if (mw[0]) model[a[0]] = d[0];
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.port == 2) chk(it.req, "collide", coll, it.valid);
      else begin
        chk(it.req, it.port ? "rt_rvalid" : "lt_rvalid", it.port ? r_v : l_v, it.valid);
        if (it.valid) chk(it.req, it.port ? "rt_rdata" : "lt_rdata", it.port ? r_q : l_q, it.data);
      end
    end
  end

  localparam logic [3:0] IDLE = 4'b1111, MRD = 4'b0101, MRDX = 4'b0111,
                         MWR = 4'b0110, SRD = 4'b1001, SRDX = 4'b1011,
                         SWR = 4'b1010, BAD = 4'b0010;

  initial begin
    {l_ms, l_fs, l_rd, l_wr} = IDLE; {r_ms, r_fs, r_rd, r_wr} = IDLE;
    l_a = 0; r_a = 0; l_d = 0; r_d = 0; l_sf = 0; r_sf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R9
    chk("R9", "lt_rvalid", l_v, 0); chk("R9", "rt_rvalid", r_v, 0);
    chk("R9", "lt_rdata", l_q, 0);  chk("R9", "rt_rdata", r_q, 0);
    chk("R9", "collide", coll, 0);
    drive("R2", IDLE, 12'h000, 8'h00, 0, IDLE, 12'h000, 8'h00, 0);
    drive("R1", MWR, 12'h000, 8'hA5, 0, MWR, 12'hFFF, 8'h3C, 0);
    drive("R10", MRD, 12'hFFF, 8'h00, 0, MRD, 12'h000, 8'h00, 0);
    drive("R4", MRDX, 12'h000, 8'h00, 0, MRDX, 12'hFFF, 8'h00, 0);
    drive("R3", MWR, 12'h010, 8'h11, 0, IDLE, 12'h000, 8'h00, 0);
    drive("R3", BAD, 12'h010, 8'h77, 0, BAD, 12'h010, 8'h66, 0);
    drive("R3", MRD, 12'h010, 8'h00, 0, MRD, 12'h010, 8'h00, 0);
    drive("R5", SWR, 12'hABD, 8'hFE, 0, SWR, 12'h007, 8'h01, 0);
    drive("R5", SWR, 12'h000, 8'h00, 0, IDLE, 12'h000, 8'h00, 0);
    drive("R5", MRD, 12'h000, 8'h00, 0, IDLE, 12'h000, 8'h00, 0);
    drive("R6", SRD, 12'hF02, 8'h00, 0, SRD, 12'h006, 8'h00, 1);
    drive("R6", SRD, 12'h003, 8'h00, 1, SRDX, 12'h006, 8'h00, 1);
    drive("R7", MWR, 12'h123, 8'h5A, 0, MWR, 12'h123, 8'hA5, 0);
    drive("R7", MRD, 12'h123, 8'h00, 0, MWR, 12'h124, 8'h0F, 0);
    drive("R7", MWR, 12'h125, 8'h01, 0, MWR, 12'h126, 8'h02, 0);
    drive("R8", MWR, 12'h200, 8'h42, 0, IDLE, 12'h000, 8'h00, 0);
    drive("R8", MWR, 12'h200, 8'h99, 0, MRD, 12'h200, 8'h00, 0);
    drive("R8", MRD, 12'h124, 8'h00, 0, MRD, 12'h200, 8'h00, 0);
    drive("R2", IDLE, 12'h000, 8'h00, 0, IDLE, 12'h000, 8'h00, 0);
    drive("R2", IDLE, 12'h000, 8'h00, 0, IDLE, 12'h000, 8'h00, 0);
    @(negedge clk);
    if (q.size() != 0) chk("R1", "queue drained", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule